// File: doc/BRIEF.md
# Transaction Retry and Unbounded-Mode Controller

This block sits beside a hardware transactional memory and owns the decision of what a core does after its transaction fails. Each core reports when a transaction opens, commits, aborts, overflows the capacity of its private cache, or makes an access that collides with a transaction that cannot be aborted. For every core the block keeps a count of consecutive failed attempts. After each failure it pulses either a retry request or, once the attempt budget is spent, a request to take the lock-based fallback path.

When unbounded support is built in, a capacity overflow does not fail the transaction. The overflowing core is instead promoted to the single global unbounded slot. While it holds that slot it cannot be aborted, and any other core that touches its data is stalled until it commits. With unbounded support left out, an overflow sends the core straight to the fallback path. Lock handling and undo of modified data belong to other blocks.

Top module: `tmx_unbounded_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, every retry, fallback, grant and stall output is low.
- R2: A core with no open transaction ignores commit, abort and overflow; `begin_i` opens a transaction. On an open transaction commit takes precedence over abort, and abort over overflow. A commit closes the transaction, raises no pulse, and clears that core's failure count.
- R3: An abort of an open transaction that is not the unbounded owner closes it and counts one failure. If fewer than MAX_TRIES consecutive failures have been counted, the core's `retry_o` bit pulses high for exactly one cycle, in the cycle after the abort.
- R4: The MAX_TRIES-th consecutive failure (100 by default) pulses `fallback_o` instead of `retry_o` and clears the count. Retry and fallback never pulse together for one core.
- R5: With UNBOUNDED_EN = 0, an overflow of an open transaction pulses `fallback_o` in the next cycle with no retry, clears the count, and no grant is ever raised.
- R6: With UNBOUNDED_EN = 1, an overflow while no core holds unbounded mode raises that core's `unb_grant_o` bit from the next cycle. It produces no retry or fallback pulse.
- R7: At most one grant bit is high at any time. When several cores overflow in the same cycle with the slot free, the lowest-numbered core wins and each other core counts a failure.
- R8: An overflow while another core holds unbounded mode counts as a failure for the overflowing core.
- R9: Abort and overflow reports from the unbounded owner are ignored: they produce no retry or fallback pulse, and the grant stays high.
- R10: A conflict report (`cfl_i`) from a core other than the owner, while an owner exists, raises that core's `stall_o` from the next cycle. The stall is held until the owner commits and is low in the cycle after that commit. The owner is never stalled.
- R11: The owner's commit clears its grant in the following cycle and frees the slot for a new overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| begin_i | input | NUM_CORES | Per-core transaction start |
| commit_i | input | NUM_CORES | Per-core transaction commit |
| abort_i | input | NUM_CORES | Per-core conflict abort |
| ovf_i | input | NUM_CORES | Per-core read/write set capacity overflow |
| cfl_i | input | NUM_CORES | Per-core access colliding with the unbounded transaction |
| retry_o | output | NUM_CORES | One-cycle pulse: re-execute the transaction |
| fallback_o | output | NUM_CORES | One-cycle pulse: run on the lock-based path |
| unb_grant_o | output | NUM_CORES | Core currently holds unbounded mode |
| stall_o | output | NUM_CORES | Core is held off by the unbounded owner |

## Verification
The hardest states to reach are the exhaustion of the attempt budget and the races around the single unbounded slot. To reach the budget, the stimulus runs one core through a full 100 begin/abort rounds. A second run of 60 failures, a commit and 60 more failures shows that the commit reset the count. The slot races are produced by overflowing two cores in the same cycle, by overflowing a third core while an owner holds the slot, and by sending aborts and overflows from the owner itself. A conflict report is raised while an owner exists, and the bench then watches the stall drop together with the grant after the owner commits. The same stimulus also drives an instance built without unbounded support, so the overflow-to-fallback path is compared in the same cycles.

// File: rtl/tmx_pkg.sv
package tmx_pkg;

    // Outcome of one cycle for one core's transaction slot.
    typedef enum logic [1:0] {
        SLOT_HOLD  = 2'd0,  // nothing resolved (or begin / granted overflow)
        SLOT_FAIL  = 2'd1,  // attempt failed, count it
        SLOT_CLOSE = 2'd2,  // committed
        SLOT_SPILL = 2'd3   // overflow with no unbounded support
    } slot_ev_e;

endpackage

// File: rtl/tmx_retry_slot.sv
module tmx_retry_slot
    import tmx_pkg::*;
#(
    parameter int MAX_TRIES = 100,
    parameter bit UNB_EN    = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic begin_i,
    input  logic commit_i,
    input  logic abort_i,
    input  logic ovf_i,
    input  logic owner_i,
    input  logic win_i,
    output logic ovf_req_o,
    output logic done_o,
    output logic retry_o,
    output logic fallback_o
);
    localparam int CW = $clog2(MAX_TRIES + 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
        logic          retry;
        logic          fall;
    } slot_t;

    slot_t    slot_q, slot_d;
    slot_ev_e ev;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        ev = SLOT_HOLD;
        if (slot_q.active) begin
            if (commit_i)                 ev = SLOT_CLOSE;
            else if (abort_i && !owner_i) ev = SLOT_FAIL;
            else if (ovf_i && !owner_i) begin
                if (UNB_EN) ev = win_i ? SLOT_HOLD : SLOT_FAIL;
                else        ev = SLOT_SPILL;
            end
        end

        cnt_inc      = slot_q.cnt + CW'(1);
        slot_d       = slot_q;
        slot_d.retry = 1'b0;
        slot_d.fall  = 1'b0;

        unique case (ev)
            SLOT_HOLD: begin
                if (!slot_q.active && begin_i) slot_d.active = 1'b1;
            end
            SLOT_CLOSE: begin
                slot_d.active = 1'b0;
                slot_d.cnt    = '0;
            end
            SLOT_SPILL: begin
                slot_d.active = 1'b0;
                slot_d.cnt    = '0;
                slot_d.fall   = 1'b1;
            end
            SLOT_FAIL: begin
                slot_d.active = 1'b0;
                if (cnt_inc >= CW'(MAX_TRIES)) begin
                    slot_d.fall = 1'b1;
                    slot_d.cnt  = '0;
                end else begin
                    slot_d.retry = 1'b1;
                    slot_d.cnt   = cnt_inc;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) slot_q <= '0;
        else         slot_q <= slot_d;
    end

    assign ovf_req_o  = UNB_EN && slot_q.active && !commit_i && !abort_i
                        && ovf_i && !owner_i;
    assign done_o     = slot_q.active && commit_i;
    assign retry_o    = slot_q.retry;
    assign fallback_o = slot_q.fall;

endmodule

// File: rtl/tmx_owner_guard.sv
module tmx_owner_guard #(
    parameter int NC = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [NC-1:0] ovf_req_i,
    input  logic [NC-1:0] done_i,
    input  logic [NC-1:0] cfl_i,
    output logic [NC-1:0] win_o,
    output logic [NC-1:0] own_o,
    output logic [NC-1:0] stall_o
);
    typedef struct packed {
        logic [NC-1:0] own;
        logic [NC-1:0] stall;
    } guard_t;

    guard_t guard_q, guard_d;
    logic   held, owner_done, taken;

    always_comb begin
        held       = |guard_q.own;
        owner_done = |(guard_q.own & done_i);

        // lowest index wins a free slot
        taken = held;
        win_o = '0;
        for (int i = 0; i < NC; i++) begin
            win_o[i] = ovf_req_i[i] && !taken;
            taken    = taken || ovf_req_i[i];
        end

        guard_d.own   = (owner_done ? '0 : guard_q.own) | win_o;
        guard_d.stall = (guard_q.stall | (cfl_i & ~guard_q.own & {NC{held}}))
                        & ~{NC{owner_done}};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) guard_q <= '0;
        else         guard_q <= guard_d;
    end

    assign own_o   = guard_q.own;
    assign stall_o = guard_q.stall;

endmodule

// File: rtl/tmx_unbounded_ctrl.sv
module tmx_unbounded_ctrl #(
    parameter int NUM_CORES    = 4,
    parameter int MAX_TRIES    = 100,
    parameter bit UNBOUNDED_EN = 1'b1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_CORES-1:0] begin_i,
    input  logic [NUM_CORES-1:0] commit_i,
    input  logic [NUM_CORES-1:0] abort_i,
    input  logic [NUM_CORES-1:0] ovf_i,
    input  logic [NUM_CORES-1:0] cfl_i,
    output logic [NUM_CORES-1:0] retry_o,
    output logic [NUM_CORES-1:0] fallback_o,
    output logic [NUM_CORES-1:0] unb_grant_o,
    output logic [NUM_CORES-1:0] stall_o
);
    logic [NUM_CORES-1:0] ovf_req, done, win, own;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
        tmx_retry_slot #(
            .MAX_TRIES (MAX_TRIES),
            .UNB_EN    (UNBOUNDED_EN)
        ) u_slot (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .begin_i    (begin_i[g]),
            .commit_i   (commit_i[g]),
            .abort_i    (abort_i[g]),
            .ovf_i      (ovf_i[g]),
            .owner_i    (own[g]),
            .win_i      (win[g]),
            .ovf_req_o  (ovf_req[g]),
            .done_o     (done[g]),
            .retry_o    (retry_o[g]),
            .fallback_o (fallback_o[g])
        );
    end

    tmx_owner_guard #(.NC(NUM_CORES)) u_guard (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ovf_req_i (ovf_req),
        .done_i    (done),
        .cfl_i     (cfl_i),
        .win_o     (win),
        .own_o     (own),
        .stall_o   (stall_o)
    );

    assign unb_grant_o = own;

endmodule

// File: rtl/tmx_unbounded_chk.sv
module tmx_unbounded_chk #(
    parameter int NC     = 4,
    parameter bit UNB_EN = 1'b1
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [NC-1:0] ovf_i,
    input logic [NC-1:0] retry_o,
    input logic [NC-1:0] fallback_o,
    input logic [NC-1:0] unb_grant_o,
    input logic [NC-1:0] stall_o
);
    // R7
    one_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(unb_grant_o));

    // R10
    stall_needs_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|stall_o) |-> (|unb_grant_o));

    // R10
    owner_not_stalled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_o & unb_grant_o) == '0);

    // R4
    pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (retry_o & fallback_o) == '0);

    for (genvar i = 0; i < NC; i++) begin : g_core
        // R9
        owner_immune_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            unb_grant_o[i] |=> (!retry_o[i] && !fallback_o[i]));

        // R6
        grant_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(unb_grant_o[i]) |-> $past(ovf_i[i]));
    end

    if (!UNB_EN) begin : g_nounb
        // R5
        no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            unb_grant_o == '0);
    end

endmodule

bind tmx_unbounded_ctrl tmx_unbounded_chk #(
    .NC     (NUM_CORES),
    .UNB_EN (UNBOUNDED_EN)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ovf_i       (ovf_i),
    .retry_o     (retry_o),
    .fallback_o  (fallback_o),
    .unb_grant_o (unb_grant_o),
    .stall_o     (stall_o)
);

// File: tb/test_tmx_unbounded_ctrl.sv
module test_tmx_unbounded_ctrl;
    localparam int NC   = 4;
    localparam int MAXT = 100;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [NC-1:0] ev_beg, ev_com, ev_abt, ev_ovf, ev_cfl;
    logic [NC-1:0] r_u, f_u, g_u, s_u;
    logic [NC-1:0] r_b, f_b, g_b, s_b;

    int n_chk = 0;
    int n_bad = 0;

    tmx_unbounded_ctrl #(.NUM_CORES(NC), .MAX_TRIES(MAXT), .UNBOUNDED_EN(1'b1))
    i_tmx_unbounded_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .begin_i(ev_beg), .commit_i(ev_com),
        .abort_i(ev_abt), .ovf_i(ev_ovf), .cfl_i(ev_cfl), .retry_o(r_u),
        .fallback_o(f_u), .unb_grant_o(g_u), .stall_o(s_u));

    tmx_unbounded_ctrl #(.NUM_CORES(NC), .MAX_TRIES(MAXT), .UNBOUNDED_EN(1'b0))
    i_tmx_unbounded_ctrl_nounb (
        .clk_i(clk), .rst_ni(rst_n), .begin_i(ev_beg), .commit_i(ev_com),
        .abort_i(ev_abt), .ovf_i(ev_ovf), .cfl_i(ev_cfl), .retry_o(r_b),
        .fallback_o(f_b), .unb_grant_o(g_b), .stall_o(s_b));

    // behavioural reference: index 0 = unbounded build, 1 = without
    bit m_act   [2][NC];
    int m_cnt   [2][NC];
    bit m_stall [2][NC];
    bit e_retry [2][NC];
    bit e_fall  [2][NC];
    int m_own   [2];

    task automatic model_step(input int k, input bit unb);
        int  own;
        int  winner;
        bit  ocommit;
        bit  fail;
        own    = m_own[k];
        winner = -1;
        if (own < 0)
            for (int i = 0; i < NC; i++)
                if (winner < 0 && unb && m_act[k][i] && !ev_com[i] && !ev_abt[i] && ev_ovf[i])
                    winner = i;
        ocommit = (own >= 0) && m_act[k][own] && ev_com[own];
        for (int i = 0; i < NC; i++) begin
            e_retry[k][i] = 1'b0;
            e_fall[k][i]  = 1'b0;
            fail = 1'b0;
            if (!m_act[k][i]) begin
                if (ev_beg[i]) m_act[k][i] = 1'b1;
            end else if (ev_com[i]) begin
                m_act[k][i] = 1'b0;
                m_cnt[k][i] = 0;
            end else if (ev_abt[i] && own != i) begin
                fail = 1'b1;
            end else if (ev_ovf[i] && own != i) begin
                if (unb) begin
                    if (winner != i) fail = 1'b1;
                end else begin
                    m_act[k][i] = 1'b0;
                    m_cnt[k][i] = 0;
                    e_fall[k][i] = 1'b1;
                end
            end
            if (fail) begin
                m_act[k][i] = 1'b0;
                if (m_cnt[k][i] + 1 >= MAXT) begin
                    e_fall[k][i] = 1'b1;
                    m_cnt[k][i]  = 0;
                end else begin
                    e_retry[k][i] = 1'b1;
                    m_cnt[k][i]   = m_cnt[k][i] + 1;
                end
            end
            m_stall[k][i] = (m_stall[k][i] || (ev_cfl[i] && own >= 0 && own != i)) && !ocommit;
        end
        if (ocommit)     m_own[k] = -1;
        if (winner >= 0) m_own[k] = winner;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_own[k] = -1;
                for (int i = 0; i < NC; i++) begin
                    m_act[k][i] = 1'b0; m_cnt[k][i] = 0; m_stall[k][i] = 1'b0;
                    e_retry[k][i] = 1'b0; e_fall[k][i] = 1'b0;
                end
            end
        end else begin
            model_step(0, 1'b1);
            model_step(1, 1'b0);
        end
    end

    task automatic check_vec(input logic [NC-1:0] act, input logic [NC-1:0] exp,
                             input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        logic [NC-1:0] er, ef, eg, es;
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < NC; i++) begin
                er[i] = e_retry[k][i];
                ef[i] = e_fall[k][i];
                eg[i] = (m_own[k] == i);
                es[i] = m_stall[k][i];
            end
            if (k == 0) begin
                check_vec(r_u, er, "R3 retry (unbounded build)");
                check_vec(f_u, ef, "R4 fallback (unbounded build)");
                check_vec(g_u, eg, "R6 grant (unbounded build)");
                check_vec(s_u, es, "R10 stall (unbounded build)");
            end else begin
                check_vec(r_b, er, "R3 retry (no-unbounded build)");
                check_vec(f_b, ef, "R5 fallback (no-unbounded build)");
                check_vec(g_b, eg, "R5 grant (no-unbounded build)");
                check_vec(s_b, es, "R10 stall (no-unbounded build)");
            end
        end
    endtask

    task automatic step(input logic [NC-1:0] bb, input logic [NC-1:0] cc,
                        input logic [NC-1:0] aa, input logic [NC-1:0] oo,
                        input logic [NC-1:0] ff);
        ev_beg = bb; ev_com = cc; ev_abt = aa; ev_ovf = oo; ev_cfl = ff;
        @(posedge clk);
        @(negedge clk);
        compare_model();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    localparam logic [NC-1:0] Z = '0;

    initial begin
        rst_n = 1'b0;
        ev_beg = Z; ev_com = Z; ev_abt = Z; ev_ovf = Z; ev_cfl = Z;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_vec(r_u | f_u | g_u | s_u, Z, "R1 reset outputs low");
        check_vec(r_b | f_b | g_b | s_b, Z, "R1 reset outputs low (no-unbounded)");
        rst_n = 1'b1;
        step(Z, Z, Z, Z, Z);
        check_vec(r_u | f_u | g_u | s_u, Z, "R1 first cycle after reset");

        // R2: events on idle cores are ignored
        step(Z, 4'b1111, 4'b1111, 4'b1111, Z);
        check_vec(r_u | f_u | g_u, Z, "R2 idle events ignored");
        check_vec(r_b | f_b, Z, "R2 idle events ignored (no-unbounded)");

        // R3 / R4: exhaust the attempt budget on core 0
        for (int n = 1; n <= MAXT; n++) begin
            step(4'b0001, Z, Z, Z, Z);
            step(Z, Z, 4'b0001, Z, Z);
            if (n < MAXT) check_vec(r_u, 4'b0001, "R3 retry below budget");
            else begin
                check_vec(f_u, 4'b0001, "R4 fallback on last attempt");
                check_vec(r_u, Z, "R4 no retry with fallback");
            end
        end

        // R2: commit clears the failure count
        for (int n = 0; n < 60; n++) begin
            step(4'b0001, Z, Z, Z, Z);
            step(Z, Z, 4'b0001, Z, Z);
        end
        step(4'b0001, Z, Z, Z, Z);
        step(Z, 4'b0001, Z, Z, Z);
        check_vec(r_u | f_u, Z, "R2 commit raises no pulse");
        for (int n = 0; n < 60; n++) begin
            step(4'b0001, Z, Z, Z, Z);
            step(Z, Z, 4'b0001, Z, Z);
            check_vec(f_u, Z, "R2 count cleared by commit");
        end

        // R6 / R5: core 1 overflows
        step(4'b0010, Z, Z, Z, Z);
        step(Z, Z, Z, 4'b0010, Z);
        check_vec(g_u, 4'b0010, "R6 overflow grants unbounded mode");
        check_vec(r_u | f_u, Z, "R6 no pulse on grant");
        check_vec(f_b, 4'b0010, "R5 overflow goes to fallback");
        check_vec(r_b | g_b, Z, "R5 no retry and no grant");

        // R9: owner is immune
        step(Z, Z, 4'b0010, Z, Z);
        check_vec(r_u | f_u, Z, "R9 owner abort ignored");
        check_vec(g_u, 4'b0010, "R9 grant kept after abort");
        step(Z, Z, Z, 4'b0010, Z);
        check_vec(r_u | f_u, Z, "R9 owner overflow ignored");

        // R8: second overflow while held
        step(4'b0100, Z, Z, Z, Z);
        step(Z, Z, Z, 4'b0100, Z);
        check_vec(r_u, 4'b0100, "R8 overflow while held fails");
        check_vec(g_u, 4'b0010, "R8 owner unchanged");

        // R10: conflicting core stalls until owner commits
        step(Z, Z, Z, Z, 4'b1010);
        check_vec(s_u, 4'b1000, "R10 stall raised, owner not stalled");
        check_vec(s_b, Z, "R10 no stall without owner");
        step(Z, Z, Z, Z, Z);
        check_vec(s_u, 4'b1000, "R10 stall held");
        step(Z, 4'b0010, Z, Z, Z);
        check_vec(g_u, Z, "R11 grant cleared after commit");
        check_vec(s_u, Z, "R10 stall released after owner commit");

        // R7: simultaneous overflow, lowest index wins
        step(4'b1100, Z, Z, Z, Z);
        step(Z, Z, Z, 4'b1100, Z);
        check_vec(g_u, 4'b0100, "R7 lowest index wins");
        check_vec(r_u, 4'b1000, "R7 loser counts a failure");
        step(Z, 4'b0100, Z, Z, Z);
        check_vec(g_u, Z, "R11 slot freed");

        // R2: commit beats abort in the same cycle
        step(4'b0001, Z, Z, Z, Z);
        step(Z, 4'b0001, 4'b0001, Z, Z);
        check_vec(r_u | f_u, Z, "R2 commit has priority over abort");

        step(Z, Z, Z, Z, Z);
        finish_run();
    end

endmodule